// File: doc/BRIEF.md
# Dual-Bridge Priority Bus-Request Arbiter

Two bridge agents share one open-drain, active-low priority-request line on a host address bus, and only one of them may pull it at a time. This block is instantiated once in each bridge. A strap input, captured while reset is held, decides the role. The arbiter bridge decides who may use the line. The secondary bridge must ask the arbiter for the line before it may drive it.

The two bridges are joined by one crossed pair of active-low handshake pins. The secondary bridge uses its output pin as a request and reads a grant on its input pin. The arbiter bridge uses the same pins the other way round: its input pin carries the other bridge's request and its output pin returns the grant. The arbiter bridge has the higher priority.

Neither role pulls the shared line unless it has first sampled the line released. Because of this, the grant can be passed on while the line is still busy, and the new owner waits until the line is free. The local logic asks for the line with a level input, `xact_i`, which stays high for as long as a local transfer needs the line. An optional input flop on the handshake pin can be chosen by parameter. It adds one cycle to every handshake reaction.

Top module: `hostbus_prio_arb`

## Requirements
- R1: The strap `role_arb_i` is captured on every clock edge while `rst_n` is low (1 = arbiter role, 0 = secondary role). During reset `hs_out_n` is 1 and `prio_oe` is 0. The captured role holds until the next reset.
- R2: In the arbiter role, a low on `hs_in_n` is the other bridge's request, and a low driven on `hs_out_n` is the grant returned to it.
- R3: An idle arbiter sets `prio_oe` on the next edge when `xact_i` is high and the line (`prio_in_n`) is sampled high. While the line is sampled low, it keeps waiting.
- R4: The arbiter has priority. While its own `xact_i` is high, it never grants, whether it is idle or owns the line. When the line is free and both bridges want it, the arbiter takes it.
- R5: The arbiter holds its grant for as long as the request is sampled low. After the first edge at which the request is sampled high, the grant negates exactly GNT_NEG_GAP edges later (default 2, never below 2).
- R6: The arbiter never drives the line while its grant output is asserted.
- R7: An idle secondary bridge asserts its request on the edge after `xact_i` is sampled high. It keeps the request asserted until it has owned the line.
- R8: A requesting secondary bridge sets `prio_oe` only on an edge where the grant is sampled low and the line is sampled high. It waits, still requesting, while the line is held by any other agent.
- R9: When `xact_i` is sampled low, an owning secondary bridge clears `prio_oe` and negates its request on the same edge.
- R10: After releasing the line, the secondary bridge does not assert its request again until it has sampled the grant negated.
- R11: The two bridges never drive the line at the same time, for any handshake latency between them.
- R12: When an owning arbiter sees `xact_i` low and a pending request, it releases the line and asserts the grant on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| role_arb_i | input | 1 | Role strap, captured during reset (1 = arbiter) |
| xact_i | input | 1 | Local transfer needs the line, active high |
| hs_in_n | input | 1 | Handshake input: request from the other bridge (arbiter) or grant (secondary), active low |
| hs_out_n | output | 1 | Handshake output: grant to the other bridge (arbiter) or request (secondary), active low |
| prio_in_n | input | 1 | Sampled level of the shared priority-request line, active low |
| prio_oe | output | 1 | Pull-down enable for the shared line |

## Verification
Two instances with opposite straps are wired crosswise through delay lines. Each delay line is set to its own latency of 0 to 4 cycles, and the roles are swapped halfway through the run. Directed sequences cover the following cases:
- priority contention while the arbiter owns the line;
- the same-edge release and grant;
- a re-request made during the grant tail;
- an outside agent holding the line while a grant is pending.

These sequences separate the priority, hand-off and released-line gates from one another. Random request lengths, idle gaps and outside line holds under each latency pair stress the mutual exclusion and the grant negation gap. The zero-latency setting shows exact edge timing. Long latencies show that no fixed grant latency is assumed.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

   // arbiter-role states
   typedef enum logic [1:0] {
      A_IDLE = 2'd0,
      A_OWN  = 2'd1,
      A_GNT  = 2'd2,
      A_TAIL = 2'd3
   } arb_st_t;

   // secondary-role states
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_REQ  = 2'd1,
      S_OWN  = 2'd2,
      S_WAIT = 2'd3
   } sec_st_t;

   // what a role engine wants on the pins, active high
   typedef struct packed {
      logic hs_act;
      logic drive;
   } role_drv_t;

endpackage

// File: rtl/hpa_arb_role.sv
module hpa_arb_role
   import hpa_pkg::*;
#(
   parameter int GAP = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  logic      loc_busy,
   input  logic      peer_req,
   input  logic      line_free,
   output role_drv_t drv
);

   localparam int CW = $clog2(GAP);
   localparam logic [CW-1:0] TAIL_LOAD = CW'(GAP - 1);

   arb_st_t       st, st_nx;
   logic [CW-1:0] cnt, cnt_nx;

   always_comb begin
      st_nx  = st;
      cnt_nx = cnt;
      case (st)
         A_IDLE: begin
            // R4: local demand wins; R3: only onto a released line
            if (loc_busy && line_free)      st_nx = A_OWN;
            else if (!loc_busy && peer_req) st_nx = A_GNT;
         end
         A_OWN: begin
            // R12: release and grant on the same edge
            if (!loc_busy) st_nx = peer_req ? A_GNT : A_IDLE;
         end
         A_GNT: begin
            if (!peer_req) begin
               st_nx  = A_TAIL;
               cnt_nx = TAIL_LOAD;
            end
         end
         A_TAIL: begin
            // R5: grant stays out for GAP edges after the request goes away
            if (cnt == '0) st_nx  = A_IDLE;
            else           cnt_nx = cnt - 1'b1;
         end
         default: st_nx = A_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         st  <= A_IDLE;
         cnt <= '0;
      end else begin
         st  <= st_nx;
         cnt <= cnt_nx;
      end
   end

   always_comb begin
      drv.hs_act = (st == A_GNT) || (st == A_TAIL);
      drv.drive  = (st == A_OWN);
   end

endmodule

// File: rtl/hpa_sec_role.sv
module hpa_sec_role
   import hpa_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  logic      loc_busy,
   input  logic      granted,
   input  logic      line_free,
   output role_drv_t drv
);

   sec_st_t st, st_nx;

   always_comb begin
      st_nx = st;
      case (st)
         // R7: ask once local demand appears
         S_IDLE: if (loc_busy) st_nx = S_REQ;
         // R8: need the grant and a released line; the request is kept
         S_REQ:  if (granted && line_free) st_nx = S_OWN;
         // R9: drop request and line together
         S_OWN:  if (!loc_busy) st_nx = S_WAIT;
         // R10: no new request until the old grant is gone
         S_WAIT: if (!granted) st_nx = S_IDLE;
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) st <= S_IDLE;
      else               st <= st_nx;
   end

   always_comb begin
      drv.hs_act = (st == S_REQ) || (st == S_OWN);
      drv.drive  = (st == S_OWN);
   end

endmodule

// File: rtl/hostbus_prio_arb.sv
module hostbus_prio_arb
   import hpa_pkg::*;
#(
   parameter int GNT_NEG_GAP = 2,
   parameter bit HS_SYNC     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic role_arb_i,
   input  logic xact_i,
   input  logic hs_in_n,
   output logic hs_out_n,
   input  logic prio_in_n,
   output logic prio_oe
);

   generate
      if (GNT_NEG_GAP < 2) begin : g_gap_bad
         $error("GNT_NEG_GAP must be at least 2");
      end
   endgenerate

   logic      role_q;
   logic      peer_act;
   logic      line_free;
   role_drv_t arb_drv, sec_drv, sel_drv;

   // R1: role captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) role_q <= role_arb_i;
   end

   generate
      if (HS_SYNC) begin : g_hs_flop
         logic hs_q;
         always_ff @(posedge clk) begin
            if (!rst_n) hs_q <= 1'b1;
            else        hs_q <= hs_in_n;
         end
         assign peer_act = ~hs_q;
      end else begin : g_hs_direct
         assign peer_act = ~hs_in_n;
      end
   endgenerate

   assign line_free = prio_in_n;

   // R2: the same pin is a request in one role and a grant in the other
   hpa_arb_role #(.GAP(GNT_NEG_GAP)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (role_q),
      .loc_busy  (xact_i),
      .peer_req  (peer_act),
      .line_free (line_free),
      .drv       (arb_drv)
   );

   hpa_sec_role u_sec (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (~role_q),
      .loc_busy  (xact_i),
      .granted   (peer_act),
      .line_free (line_free),
      .drv       (sec_drv)
   );

   always_comb begin
      sel_drv = role_q ? arb_drv : sec_drv;
   end

   assign hs_out_n = ~sel_drv.hs_act;
   assign prio_oe  = sel_drv.drive;

endmodule

// File: rtl/hostbus_prio_arb_chk.sv
module hostbus_prio_arb_chk #(
   parameter bit HS_SYNC = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic role_q,
   input logic xact_i,
   input logic hs_in_n,
   input logic hs_out_n,
   input logic prio_in_n,
   input logic prio_oe
);

   assert_take_needs_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prio_oe) |-> $past(prio_in_n));

   assert_arb_takes_free_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (role_q && hs_out_n && !prio_oe && xact_i && prio_in_n) |=> prio_oe); // R4 too

   assert_grant_neg_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (role_q && $rose(hs_out_n)) |-> ($past(hs_in_n, 2) && $past(hs_in_n, 3)));

   assert_sec_release_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!role_q && $fell(prio_oe)) |-> $rose(hs_out_n));

   assert_sec_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!role_q && !hs_out_n && !prio_oe) |=> !hs_out_n);

   generate
      if (!HS_SYNC) begin : g_pin_direct
         assert_sec_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!role_q && $rose(prio_oe)) |-> !$past(hs_in_n));

         assert_sec_no_rereq_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!role_q && hs_out_n && !hs_in_n) |=> hs_out_n);
      end
   endgenerate

endmodule

bind hostbus_prio_arb hostbus_prio_arb_chk #(.HS_SYNC(HS_SYNC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .role_q    (role_q),
   .xact_i    (xact_i),
   .hs_in_n   (hs_in_n),
   .hs_out_n  (hs_out_n),
   .prio_in_n (prio_in_n),
   .prio_oe   (prio_oe)
);

// File: tb/hostbus_prio_arb_tb.sv
module hostbus_prio_arb_tb;

   localparam int GAP = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [1:0] strap = 2'b01;
   logic [1:0] xact = 2'b00;
   logic       ext_hold = 1'b0;
   wire  [1:0] hs_out_n;
   wire  [1:0] oe;
   logic [1:0] hs_in_n;
   wire        line_n;
   int         lat [2] = '{0, 0};
   logic [7:0] sr  [2];

   int chk_n = 0;
   int err_n = 0;

   assign line_n = ~(oe[0] | oe[1] | ext_hold);

   // handshake delay lines, crossed between the two instances
   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (!rst_n) sr[i] <= 8'hFF;
         else        sr[i] <= {sr[i][6:0], hs_out_n[i]};
      end
   end

   always_comb begin
      hs_in_n[1] = (lat[0] == 0) ? hs_out_n[0] : sr[0][lat[0]-1];
      hs_in_n[0] = (lat[1] == 0) ? hs_out_n[1] : sr[1][lat[1]-1];
   end

   hostbus_prio_arb u_dut (
      .clk(clk), .rst_n(rst_n), .role_arb_i(strap[0]), .xact_i(xact[0]),
      .hs_in_n(hs_in_n[0]), .hs_out_n(hs_out_n[0]), .prio_in_n(line_n), .prio_oe(oe[0]));

   hostbus_prio_arb u_peer (
      .clk(clk), .rst_n(rst_n), .role_arb_i(strap[1]), .xact_i(xact[1]),
      .hs_in_n(hs_in_n[1]), .hs_out_n(hs_out_n[1]), .prio_in_n(line_n), .prio_oe(oe[1]));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      chk_n++;
      if (!ok) begin
         err_n++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- behavioural reference model ----------------
   bit m_role [2];
   int m_gl   [2];   // arbiter: 0 no grant, -1 held open, >0 edges left
   bit m_own  [2];
   bit m_req  [2];
   bit m_wait [2];

   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         bit pr;
         bit fr;
         pr = !hs_in_n[i];
         fr = line_n;
         if (!rst_n) begin
            m_role[i] = strap[i];
            m_gl[i] = 0; m_own[i] = 0; m_req[i] = 0; m_wait[i] = 0;
         end else if (m_role[i]) begin
            if (m_gl[i] == -1) begin
               if (!pr) m_gl[i] = GAP;
            end else if (m_gl[i] > 0) begin
               m_gl[i]--;
            end else if (m_own[i]) begin
               if (!xact[i]) begin
                  m_own[i] = 0;
                  if (pr) m_gl[i] = -1;
               end
            end else if (xact[i] && fr) begin
               m_own[i] = 1;
            end else if (!xact[i] && pr) begin
               m_gl[i] = -1;
            end
         end else begin
            if (m_wait[i]) begin
               if (!pr) m_wait[i] = 0;
            end else if (m_own[i]) begin
               if (!xact[i]) begin
                  m_own[i] = 0; m_req[i] = 0; m_wait[i] = 1;
               end
            end else if (m_req[i]) begin
               if (pr && fr) m_own[i] = 1;
            end else if (xact[i]) begin
               m_req[i] = 1;
            end
         end
      end
   end

   // per-cycle comparison and protocol monitors
   int  since [2];
   bit  prev_out [2];

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 2; i++) begin
            bit exp_hs;
            exp_hs = m_role[i] ? (m_gl[i] == 0) : !m_req[i];
            chk(hs_out_n[i] == exp_hs, m_role[i] ? "R5 grant pin" : "R7 request pin",
                hs_out_n[i], exp_hs);
            chk(oe[i] == m_own[i], m_role[i] ? "R3 arbiter drive" : "R8 secondary drive",
                oe[i], m_own[i]);
            if (m_role[i]) begin
               chk(!(oe[i] && !hs_out_n[i]), "R6 drive while granting", oe[i], 0);
               if (hs_in_n[i]) since[i]++;
               else            since[i] = 0;
               if (!prev_out[i] && hs_out_n[i])
                  chk(since[i] >= 3, "R5 grant negation gap", since[i], 3);
            end
            prev_out[i] = hs_out_n[i];
         end
         chk(!(oe[0] && oe[1]), "R11 both drive", oe, 0);
      end else begin
         for (int i = 0; i < 2; i++) begin
            since[i] = 0;
            prev_out[i] = 1'b1;
         end
      end
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         err_n++;
         $display("FAIL R11 watchdog: actual %0d cycles expected below 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", chk_n, err_n);
         $finish;
      end
   end

   // random agents
   int idle_c [2] = '{0, 0};
   int hold_c [2] = '{0, 0};
   int ext_c = 0;

   task automatic agent_step();
      for (int i = 0; i < 2; i++) begin
         if (!xact[i]) begin
            if (idle_c[i] == 0) begin
               xact[i]   = 1'b1;
               hold_c[i] = 1 + int'($urandom % 6);
            end else idle_c[i]--;
         end else if (oe[i]) begin
            if (hold_c[i] == 0) begin
               xact[i]   = 1'b0;
               idle_c[i] = int'($urandom % 8);
            end else hold_c[i]--;
         end
      end
      if (ext_hold) begin
         if (ext_c == 0) ext_hold = 1'b0;
         else            ext_c--;
      end else if (!oe[0] && !oe[1] && ($urandom % 16 == 0)) begin
         ext_hold = 1'b1;
         ext_c    = int'($urandom % 3);
      end
   endtask

   initial begin
      // R1: reset state
      tick(4);
      chk(hs_out_n == 2'b11 && oe == 2'b00, "R1 reset outputs", {hs_out_n, oe}, 4'b1100);
      rst_n = 1'b1;
      tick(1);

      // R3: arbiter (u_dut) takes a free line
      xact[0] = 1'b1;
      tick(1);
      chk(oe[0] == 1'b1, "R3 arbiter takes free line", oe[0], 1);

      // R7 / R4: secondary requests, arbiter keeps line and withholds grant
      xact[1] = 1'b1;
      tick(1);
      chk(hs_out_n[1] == 1'b0, "R7 request asserted", hs_out_n[1], 0);
      tick(3);
      chk(hs_out_n[0] == 1'b1 && oe[0] == 1'b1, "R4 arbiter priority", {hs_out_n[0], oe[0]}, 2'b11);

      // R12 / R2: release and grant on one edge
      xact[0] = 1'b0;
      tick(1);
      chk(oe[0] == 1'b0 && hs_out_n[0] == 1'b0, "R12 same-edge hand-off", {oe[0], hs_out_n[0]}, 0);
      chk(hs_out_n[0] == 1'b0, "R2 grant on request pin", hs_out_n[0], 0);
      tick(1);
      chk(oe[1] == 1'b1, "R8 secondary takes line with grant", oe[1], 1);

      // R9 / R5 / R10
      tick(2);
      xact[1] = 1'b0;
      tick(1);
      chk(hs_out_n[1] == 1'b1 && oe[1] == 1'b0, "R9 joint release", {hs_out_n[1], oe[1]}, 2'b10);
      xact[1] = 1'b1;
      tick(1);
      chk(hs_out_n[0] == 1'b0, "R5 grant held in tail", hs_out_n[0], 0);
      tick(1);
      chk(hs_out_n[0] == 1'b0, "R5 grant held in tail", hs_out_n[0], 0);
      chk(hs_out_n[1] == 1'b1, "R10 no re-request under grant", hs_out_n[1], 1);
      tick(1);
      chk(hs_out_n[0] == 1'b1, "R5 grant negated after gap", hs_out_n[0], 1);
      tick(1);
      chk(hs_out_n[1] == 1'b1, "R10 no re-request before grant seen gone", hs_out_n[1], 1);
      tick(1);
      chk(hs_out_n[1] == 1'b0, "R7 request after grant negation", hs_out_n[1], 0);
      tick(2);
      chk(oe[1] == 1'b1, "R8 secondary owns again", oe[1], 1);
      xact[1] = 1'b0;
      tick(8);

      // R8: outside agent holds the line while the grant is out
      ext_hold = 1'b1;
      xact[1]  = 1'b1;
      tick(6);
      chk(hs_out_n[0] == 1'b0 && oe[1] == 1'b0, "R8 wait for released line", {hs_out_n[0], oe[1]}, 0);
      ext_hold = 1'b0;
      tick(1);
      chk(oe[1] == 1'b1, "R8 take after release", oe[1], 1);
      xact[1] = 1'b0;
      tick(8);

      // R3: arbiter waits on a busy line
      ext_hold = 1'b1;
      xact[0]  = 1'b1;
      tick(4);
      chk(oe[0] == 1'b0, "R3 arbiter waits on busy line", oe[0], 0);
      ext_hold = 1'b0;
      tick(1);
      chk(oe[0] == 1'b1, "R3 arbiter takes released line", oe[0], 1);
      xact[0] = 1'b0;
      tick(6);

      // random phases with varying latencies; roles swap at phase 6
      for (int ph = 0; ph < 12; ph++) begin
         if (ph == 6) begin
            rst_n = 1'b0;
            strap = 2'b10;
            tick(3);
            rst_n = 1'b1;
            tick(1);
            xact[1] = 1'b1;
            tick(1);
            chk(oe[1] == 1'b1, "R1 swapped role takes line", oe[1], 1);
            xact[1] = 1'b0;
            tick(4);
         end
         lat[0] = int'($urandom % 5);
         lat[1] = int'($urandom % 5);
         for (int i = 0; i < 2; i++) begin
            idle_c[i] = int'($urandom % 4);
            hold_c[i] = 0;
         end
         repeat (600) begin
            tick(1);
            agent_step();
         end
         xact     = 2'b00;
         ext_hold = 1'b0;
         tick(30);
         chk(oe == 2'b00 && hs_out_n == 2'b11, "R11 quiet after phase", {hs_out_n, oe}, 4'b1100);
      end

      $display("Simulation finished: %0d checks, %0d errors", chk_n, err_n);
      $finish;
   end

endmodule